// File: doc/BRIEF.md
# PWM Manual Override Synchronizer

This block sits between the duty comparators of a three-pair PWM generator and the output pins. Software can force any of the six outputs to a fixed logic level in place of its comparator signal. The forced outputs then pass through a dead-time gate, which delays every rising edge by a programmable number of clock cycles. Forcing does not bypass the gate. When a low-side pin is forced active in complementary mode, it follows the inverse of its high-side partner instead of a fixed level.

A register write loads a force-enable word and a force-level word. With synchronization off, the new setting takes effect at once. With synchronization on, the write lands in shadow registers. The shadow registers are copied to the active registers only at time-base events: at timer zero in edge-aligned counting, and at both timer zero and timer equal to period in center-aligned counting.

Top module: `pwm_force_sync`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset with all raw inputs low, all six outputs are low and no override is active.
- R2: An output whose force bit is clear follows its raw input: a fall appears one clock after the input falls, and a rise appears one clock plus the dead-time count after the input rises.
- R3: Bit k of the force and level words (k = 0..2) selects the high side of pair k. Bit 3+k selects the low side of pair k. A pin whose force bit is set is driven from its level bit instead of its raw input.
- R4: With synchronization off, a write updates the active override at the clock edge that samples it. The output reflects the change one edge later.
- R5: With synchronization on and edge-aligned counting, a written override takes effect only at the edge where the timer is zero. A timer equal to the period has no effect.
- R6: With synchronization on and center-aligned counting, the shadow override is copied at the edge where the timer is zero and also at the edge where the timer equals the period.
- R7: In complementary mode, a low-side pin that is forced with level 1 is driven as the inverse of its pair's high-side signal after that signal's own override. A low-side pin forced with level 0 is driven low.
- R8: Dead time delays rising edges by `dead` clock cycles. This also applies to forced pins. A falling edge still appears one clock after its input falls.
- R9: In complementary mode, the high and low outputs of a pair are never high together. If both of a pair's inputs are high, both of its outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_pwm | input | 6 | Comparator outputs. Bits 0..2 are the high sides and bits 3..5 are the low sides |
| cfg_we | input | 1 | Write strobe for the override words |
| cfg_force | input | 6 | Force-enable word, same bit layout as raw_pwm |
| cfg_level | input | 6 | Forced level word, same bit layout |
| sync_en | input | 1 | Hold override writes until time-base events |
| compl_mode | input | 1 | Complementary pair mode |
| center_mode | input | 1 | 1 selects center-aligned counting, 0 selects edge-aligned |
| tmr | input | 16 | Time-base counter value |
| period | input | 16 | Time-base period value |
| dead | input | 8 | Dead-time count in clock cycles |
| pwm_out | output | 6 | Output pins, same bit layout |

## Verification
The bench writes overrides while the timer sits at the period value in edge-aligned mode. A design that treats every timer match as an update point would change the pins early there. The same timer value is then applied in center-aligned mode, where the update must occur. The bench times forced rising edges cycle by cycle against the dead-time count, so a design that skips the gate for forced pins shows up as an early rise. It also drives both inputs of a pair high in complementary mode and forces a low-side pin active while its partner toggles. A mux that applies the stored level, or that lets both pins of a pair rise together, drives wrong pin values there.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

  // Update point: timer at zero, or at period when counting center-aligned.
  function automatic logic sync_point(input logic at_zero, input logic at_period,
                                      input logic center);
    return at_zero | (center & at_period);
  endfunction

  // High-side pin after override.
  function automatic logic force_hi(input logic raw, input logic en, input logic lvl);
    return en ? lvl : raw;
  endfunction

  // Low-side pin after override; forced-active in complementary mode tracks ~partner.
  function automatic logic force_lo(input logic raw, input logic en, input logic lvl,
                                    input logic compl, input logic partner);
    if (!en)           return raw;
    if (compl && lvl)  return ~partner;
    return lvl;
  endfunction

endpackage

// File: rtl/pwm_ovr_regs.sv
module pwm_ovr_regs #(
  parameter int NOUT = 6,
  parameter int TW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NOUT-1:0] wr_force,
  input  logic [NOUT-1:0] wr_level,
  input  logic            sync_en,
  input  logic            center_mode,
  input  logic [TW-1:0]   tmr,
  input  logic [TW-1:0]   period,
  output logic [NOUT-1:0] act_force,
  output logic [NOUT-1:0] act_level,
  output logic [NOUT-1:0] shd_force,
  output logic [NOUT-1:0] shd_level,
  output logic            sync_pt
);
  import pwm_ovr_pkg::*;

  logic at_zero, at_period;
  assign at_zero   = (tmr == '0);
  assign at_period = (tmr == period);
  assign sync_pt   = sync_point(at_zero, at_period, center_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_force <= '0;
      shd_level <= '0;
    end else if (wr_en) begin
      shd_force <= wr_force;
      shd_level <= wr_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_force <= '0;
      act_level <= '0;
    end else if (!sync_en && wr_en) begin
      act_force <= wr_force;
      act_level <= wr_level;
    end else if (sync_en && sync_pt) begin
      act_force <= shd_force;
      act_level <= shd_level;
    end
  end

endmodule

// File: rtl/pwm_ovr_mux.sv
module pwm_ovr_mux #(
  parameter int NPAIR = 3,
  localparam int NOUT = 2 * NPAIR
) (
  input  logic [NOUT-1:0] raw,
  input  logic [NOUT-1:0] act_force,
  input  logic [NOUT-1:0] act_level,
  input  logic            compl_mode,
  output logic [NOUT-1:0] forced
);
  import pwm_ovr_pkg::*;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign forced[k] = force_hi(raw[k], act_force[k], act_level[k]);
    assign forced[NPAIR+k] = force_lo(raw[NPAIR+k], act_force[NPAIR+k],
                                      act_level[NPAIR+k], compl_mode, forced[k]);
  end

endmodule

// File: rtl/pwm_dead_gate.sv
module pwm_dead_gate #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_own,
  input  logic           in_mate,
  input  logic           gate_mate,
  input  logic [DTW-1:0] dead,
  output logic           out_q
);
  logic [DTW-1:0] cnt;
  logic           arm;

  // In complementary mode a rise is only armed while the partner is low.
  assign arm = in_own & ~(gate_mate & in_mate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (!arm) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (cnt >= dead) begin
      out_q <= 1'b1;
    end else begin
      cnt   <= cnt + DTW'(1);
      out_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_force_sync.sv
module pwm_force_sync #(
  parameter int NPAIR = 3,
  parameter int TW    = 16,
  parameter int DTW   = 8,
  localparam int NOUT = 2 * NPAIR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOUT-1:0] raw_pwm,
  input  logic            cfg_we,
  input  logic [NOUT-1:0] cfg_force,
  input  logic [NOUT-1:0] cfg_level,
  input  logic            sync_en,
  input  logic            compl_mode,
  input  logic            center_mode,
  input  logic [TW-1:0]   tmr,
  input  logic [TW-1:0]   period,
  input  logic [DTW-1:0]  dead,
  output logic [NOUT-1:0] pwm_out
);
  logic [NOUT-1:0] act_force, act_level, shd_force, shd_level, forced;
  logic            sync_pt;

  pwm_ovr_regs #(.NOUT(NOUT), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_force(cfg_force), .wr_level(cfg_level),
    .sync_en(sync_en), .center_mode(center_mode),
    .tmr(tmr), .period(period),
    .act_force(act_force), .act_level(act_level),
    .shd_force(shd_force), .shd_level(shd_level),
    .sync_pt(sync_pt)
  );

  pwm_ovr_mux #(.NPAIR(NPAIR)) u_mux (
    .raw(raw_pwm), .act_force(act_force), .act_level(act_level),
    .compl_mode(compl_mode), .forced(forced)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_dt
    localparam int MATE = (i < NPAIR) ? i + NPAIR : i - NPAIR;
    pwm_dead_gate #(.DTW(DTW)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .in_own(forced[i]), .in_mate(forced[MATE]),
      .gate_mate(compl_mode), .dead(dead),
      .out_q(pwm_out[i])
    );
  end

endmodule

// File: rtl/pwm_force_sync_chk.sv
module pwm_force_sync_chk #(
  parameter int NPAIR = 3,
  localparam int NOUT = 2 * NPAIR
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sync_en,
  input logic            cfg_we,
  input logic [NOUT-1:0] cfg_force,
  input logic [NOUT-1:0] cfg_level,
  input logic            compl_mode,
  input logic [NOUT-1:0] pwm_out,
  input logic [NOUT-1:0] act_force,
  input logic [NOUT-1:0] act_level,
  input logic [NOUT-1:0] shd_force,
  input logic [NOUT-1:0] shd_level,
  input logic [NOUT-1:0] forced,
  input logic            sync_pt
);

  a_r4_async_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && cfg_we) |=> (act_force == $past(cfg_force) && act_level == $past(cfg_level)));

  a_r5_hold_off_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !sync_pt) |=> ($stable(act_force) && $stable(act_level)));

  a_r6_copy_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && sync_pt) |=> (act_force == $past(shd_force) && act_level == $past(shd_level)));

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair_chk
    a_r7_lo_tracks_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (compl_mode && act_force[NPAIR+k] && act_level[NPAIR+k]) |-> (forced[NPAIR+k] != forced[k]));

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      compl_mode |=> !(pwm_out[k] && pwm_out[NPAIR+k]));
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out_chk
    a_r8_fast_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !forced[i] |=> !pwm_out[i]);
  end

endmodule

bind pwm_force_sync pwm_force_sync_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .cfg_we(cfg_we),
  .cfg_force(cfg_force), .cfg_level(cfg_level), .compl_mode(compl_mode),
  .pwm_out(pwm_out), .act_force(act_force), .act_level(act_level),
  .shd_force(shd_force), .shd_level(shd_level), .forced(forced), .sync_pt(sync_pt)
);

// File: tb/pwm_force_sync_test.sv
module pwm_force_sync_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  raw_pwm = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_force = '0;
  logic [5:0]  cfg_level = '0;
  logic        sync_en = 1'b0;
  logic        compl_mode = 1'b0;
  logic        center_mode = 1'b0;
  logic [15:0] tmr = 16'd5;
  logic [15:0] period = 16'd9;
  logic [7:0]  dead = '0;
  logic [5:0]  pwm_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_force_sync uut (
    .clk(clk), .rst_n(rst_n), .raw_pwm(raw_pwm), .cfg_we(cfg_we),
    .cfg_force(cfg_force), .cfg_level(cfg_level), .sync_en(sync_en),
    .compl_mode(compl_mode), .center_mode(center_mode), .tmr(tmr),
    .period(period), .dead(dead), .pwm_out(pwm_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    n_run++;
    if (pwm_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%b expected=%b", req, pwm_out, exp);
    end
  endtask

  // Write occurs at the posedge inside this task; returns on the following negedge.
  task automatic write(input logic [5:0] f, input logic [5:0] l);
    cfg_force = f; cfg_level = l; cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    step(3);
    check("R1 in reset", 6'b000000);
    rst_n = 1'b1;
    step(1);
    check("R1 after reset", 6'b000000);
  endtask

  task automatic t_pass;
    raw_pwm = 6'b010101; step(1);
    check("R2 pass pattern a", 6'b010101);
    raw_pwm = 6'b101010; step(1);
    check("R2 pass pattern b", 6'b101010);
    raw_pwm = 6'b000000; step(1);
  endtask

  task automatic t_async;
    raw_pwm = 6'b000001; step(2);
    write(6'b000001, 6'b000000);
    check("R4 not before next edge", 6'b000001);
    step(1);
    check("R4 forced low", 6'b000000);
    write(6'b100000, 6'b100000);
    step(1);
    check("R3 low side of pair 2 forced high", 6'b100001);
    write(6'b000000, 6'b000000);
    step(1);
    check("R4 release", 6'b000001);
    raw_pwm = 6'b000000; step(1);
  endtask

  task automatic t_dead_forced;
    dead = 8'd3;
    write(6'b000010, 6'b000010);
    step(3);
    check("R8 forced rise held by dead time", 6'b000000);
    step(1);
    check("R8 forced rise after dead time", 6'b000010);
    write(6'b000000, 6'b000000);
    step(1);
    check("R8 fall one clock", 6'b000000);
    dead = 8'd0;
  endtask

  task automatic t_sync_edge;
    sync_en = 1'b1; center_mode = 1'b0; tmr = 16'd5;
    raw_pwm = 6'b000100; step(2);
    write(6'b000100, 6'b000000);
    step(3);
    check("R5 held before zero", 6'b000100);
    tmr = 16'd9; step(2);
    check("R5 period ignored in edge mode", 6'b000100);
    tmr = 16'd0; step(1);
    tmr = 16'd5; step(1);
    check("R5 applied at zero", 6'b000000);
    write(6'b000000, 6'b000000);
    tmr = 16'd0; step(1);
    tmr = 16'd5; step(1);
    check("R5 release at zero", 6'b000100);
  endtask

  task automatic t_sync_center;
    center_mode = 1'b1;
    write(6'b000100, 6'b000000);
    step(2);
    check("R6 held before event", 6'b000100);
    tmr = 16'd9; step(1);
    tmr = 16'd5; step(1);
    check("R6 applied at period", 6'b000000);
    write(6'b000000, 6'b000000);
    tmr = 16'd0; step(1);
    tmr = 16'd5; step(1);
    check("R6 applied at zero", 6'b000100);
    sync_en = 1'b0; center_mode = 1'b0; raw_pwm = 6'b000000; step(1);
  endtask

  task automatic t_compl;
    compl_mode = 1'b1; dead = 8'd0;
    write(6'b001000, 6'b001000);
    step(1);
    check("R7 forced low tracks low partner", 6'b001000);
    raw_pwm = 6'b000001; step(1);
    check("R7 forced low tracks high partner", 6'b000001);
    write(6'b001000, 6'b000000);
    raw_pwm = 6'b000000; step(1);
    check("R7 forced low level 0", 6'b000000);
  endtask

  task automatic t_compl_dead;
    dead = 8'd2;
    write(6'b001000, 6'b001000);
    raw_pwm = 6'b000001; step(4);
    check("R8 high side up", 6'b000001);
    raw_pwm = 6'b000000; step(1);
    check("R8 high fell, low waits", 6'b000000);
    step(1);
    check("R8 low still in dead time", 6'b000000);
    step(1);
    check("R8 low rises after dead time", 6'b001000);
    dead = 8'd0;
  endtask

  task automatic t_overlap;
    write(6'b000000, 6'b000000);
    raw_pwm = 6'b010010; step(2);
    check("R9 both inputs high gives both low", 6'b000000);
    raw_pwm = 6'b000010; step(1);
    check("R9 single side passes", 6'b000010);
    compl_mode = 1'b0; raw_pwm = 6'b000000; step(1);
  endtask

  initial begin
    step(1);
    t_reset;
    t_pass;
    t_async;
    t_dead_forced;
    t_sync_edge;
    t_sync_center;
    t_compl;
    t_compl_dead;
    t_overlap;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule